// File: doc/BRIEF.md
# Hybrid Coarse/Fine Digital PWM Generator

This block drives one power switch with a pulse-width-modulated signal whose duty cycle is set by an 11-bit word. The word is split in two. Its upper six bits are compared against a slow coarse counter, which picks the coarse slot in which the pulse ends. Its lower five bits pick one of 32 taps on a delay chain, which places the falling edge at a fine step inside that slot. Each path raises its own set and reset qualifiers. The two set qualifiers are ANDed, the two reset qualifiers are ANDed, and the results drive a set/reset latch whose state is the PWM output.

The fine delay chain is modelled as a synchronous shift register on the fast clock. The coarse counter advances once every 32 fast cycles through a clock enable, so one switching period lasts 2048 fast cycles. The duty word goes into effect only at a period boundary, so a change in the middle of a period cannot truncate or stretch the pulse in flight. Clearing the enable parks the generator with the output low. The next enabled cycle starts a new period.

Top module: `hybridPwm`

## Requirements
- R1: While rstN is low, pwmOut is low, the period position returns to zero and the active duty is cleared to zero.
- R2: When enabled, one period is exactly 2048 fast clock cycles (32 fine steps in each of 64 coarse slots). For a nonzero active duty, pwmOut is high in the cycle that follows the first cycle of each period.
- R3: For an active duty D from 1 to 2046, pwmOut is high for exactly D fast cycles per period. It falls in the cycle that follows period position D.
- R4: Duty bits [10:5] select the coarse slot and bits [4:0] select the fine step within it. A duty below 32 ends inside the first slot, and a multiple of 32 ends on a slot's first fine step.
- R5: An active duty of 0 keeps pwmOut low for the whole period, because reset takes priority over set.
- R6: An active duty of 2047 keeps pwmOut high for all 2048 cycles of the period, with no falling edge.
- R7: The duty input is captured only in the last cycle of a period, and in every cycle while en is low. Changes at other times have no effect on the pulse in flight.
- R8: When en is low, pwmOut is low in the following cycle and the period position is held at zero. The first cycle with en high is period position 0, and it runs with the duty present in the last disabled cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock; the delay chain steps on every edge, the coarse counter every 32nd |
| rstN | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run enable; low parks the generator with the output low |
| duty | input | 11 | Requested duty in fast-clock cycles per 2048-cycle period |
| pwmOut | output | 1 | PWM drive, the state of the set/reset latch |

## Verification
The bench aims at the edges of the duty range. At a duty of zero, set and reset coincide, and a latch with the wrong priority would emit a one-cycle glitch. At full scale, a generator that does not suppress reset would drop low for one cycle at the end of the period. Duties of 1, 17, 32, 33 and 2046 exercise the seam between fine and coarse, where a tap or slot off by one shifts the falling edge by one or 32 cycles. These show up both in the cycle-by-cycle comparison and in the per-period high-time count. A duty change in mid-period and an enable dropped in mid-period catch a design that samples the duty too early or fails to restart cleanly at position 0.

// File: rtl/hybridPwmPkg.sv
package hybridPwmPkg;
  typedef struct packed {
    logic run;
    logic coarseZero;
    logic phaseZero;
    logic loadDuty;
    logic clear;
  } ctlStrobe_t;
endpackage

// File: rtl/hybridPwmCtl.sv
module hybridPwmCtl
  import hybridPwmPkg::*;
#(
  parameter int COARSE_W = 6,
  parameter int FINE_W   = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                en,
  output logic [COARSE_W-1:0] coarse,
  output ctlStrobe_t          strobes
);
  localparam logic [FINE_W-1:0]   LAST_PHASE = {FINE_W{1'b1}};
  localparam logic [COARSE_W-1:0] LAST_SLOT  = {COARSE_W{1'b1}};

  logic [FINE_W-1:0] phase;

  always_ff @(posedge clk) begin
    if (!rstN || !en) begin
      phase  <= '0;
      coarse <= '0;
    end else begin
      phase <= phase + 1'b1;
      if (phase == LAST_PHASE) coarse <= coarse + 1'b1;
    end
  end

  always_comb begin
    strobes.run        = en;
    strobes.coarseZero = (coarse == '0);
    strobes.phaseZero  = (phase == '0);
    strobes.loadDuty   = !en || ((phase == LAST_PHASE) && (coarse == LAST_SLOT));
    strobes.clear      = !en;
  end

  // R2
  coarse_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (en && phase != LAST_PHASE) |=> $stable(coarse));

  // R8
  idle_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> (phase == '0 && coarse == '0));
endmodule

// File: rtl/hybridPwmPath.sv
module hybridPwmPath
  import hybridPwmPkg::*;
#(
  parameter int COARSE_W = 6,
  parameter int FINE_W   = 5
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [COARSE_W+FINE_W-1:0]   duty,
  input  logic [COARSE_W-1:0]          coarse,
  input  ctlStrobe_t                   strobes,
  output logic                         q
);
  localparam int DUTY_W = COARSE_W + FINE_W;
  localparam int TAPS   = 1 << FINE_W;

  logic [DUTY_W-1:0] dutyAct;
  logic [TAPS-1:1]   chain;
  logic [TAPS-1:0]   tapBus;
  logic              coarseHit, slotPulse, fineHit, fullScale;
  logic              setEv, rstEv;

  always_ff @(posedge clk) begin
    if (!rstN)                 dutyAct <= '0;
    else if (strobes.loadDuty) dutyAct <= duty;
  end

  assign coarseHit = (coarse == dutyAct[DUTY_W-1:FINE_W]);
  assign slotPulse = strobes.run && coarseHit && strobes.phaseZero;

  always_ff @(posedge clk) begin
    if (!rstN || strobes.clear) chain <= '0;
    else                        chain <= {chain[TAPS-2:1], slotPulse};
  end

  assign tapBus[0] = slotPulse;
  for (genvar k = 1; k < TAPS; k++) begin : g_tap
    assign tapBus[k] = chain[k];
  end

  assign fineHit   = tapBus[dutyAct[FINE_W-1:0]];
  assign fullScale = &dutyAct;

  // set: coarse qualifier AND fine qualifier; reset likewise
  assign setEv = strobes.run && strobes.coarseZero && strobes.phaseZero;
  assign rstEv = strobes.run && coarseHit && fineHit && !fullScale;

  always_ff @(posedge clk) begin
    if (!rstN || strobes.clear) q <= 1'b0;
    else if (rstEv)             q <= 1'b0;
    else if (setEv)             q <= 1'b1;
  end

  // R7
  duty_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadDuty |=> $stable(dutyAct));

  // R6
  full_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.run && fullScale && q) |=> q);

  // R5
  zero_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.run && dutyAct == '0 && !q) |=> !q);
endmodule

// File: rtl/hybridPwm.sv
module hybridPwm
  import hybridPwmPkg::*;
#(
  parameter int COARSE_W = 6,
  parameter int FINE_W   = 5,
  localparam int DUTY_W  = COARSE_W + FINE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              en,
  input  logic [DUTY_W-1:0] duty,
  output logic              pwmOut
);
  ctlStrobe_t          strobes;
  logic [COARSE_W-1:0] coarse;

  hybridPwmCtl #(.COARSE_W(COARSE_W), .FINE_W(FINE_W)) u_ctl (
    .clk(clk), .rstN(rstN), .en(en), .coarse(coarse), .strobes(strobes)
  );

  hybridPwmPath #(.COARSE_W(COARSE_W), .FINE_W(FINE_W)) u_path (
    .clk(clk), .rstN(rstN), .duty(duty), .coarse(coarse),
    .strobes(strobes), .q(pwmOut)
  );

  // R8
  idle_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> !pwmOut);
endmodule

// File: tb/hybridPwm_tb.sv
`timescale 1ns/1ps
module hybridPwm_tb;
  localparam int PERIOD = 2048;
  localparam int FULL   = 2047;

  logic        clk = 1'b0;
  logic        rstN, en;
  logic [10:0] duty;
  logic        pwmOut;

  always #2.5 clk = ~clk;

  hybridPwm u_dut (.clk(clk), .rstN(rstN), .en(en), .duty(duty), .pwmOut(pwmOut));

  int    compared = 0, mismatched = 0;
  string curReq = "R1";
  bit    checking = 1'b0;
  bit    finished = 1'b0;

  // behavioural reference: period position, active duty, latch state
  int mIdx = 0, mAct = 0, mQ = 0;
  always @(posedge clk) begin
    if (!rstN) begin
      mIdx = 0; mQ = 0; mAct = 0;
    end else if (!en) begin
      mIdx = 0; mQ = 0; mAct = int'(duty);
    end else begin
      if (mIdx == mAct && mAct != FULL) mQ = 0;
      else if (mIdx == 0)               mQ = 1;
      if (mIdx == PERIOD - 1) mAct = int'(duty);
      mIdx = (mIdx + 1) % PERIOD;
    end
  end

  // per-cycle comparison and per-period high-time count
  int    hiCnt = 0, expHi = 0;
  bit    winValid = 1'b0;
  string winReq = "R3";
  always @(negedge clk) begin
    if (checking && !finished) begin
      compared++;
      if (pwmOut !== mQ[0]) begin
        mismatched++;
        $display("FAIL %s: pwmOut=%0d expected=%0d at position %0d", curReq, pwmOut, mQ, mIdx);
      end
      if (!rstN || !en) begin
        winValid = 1'b0;
      end else if (mIdx == 1) begin
        if (winValid) begin
          compared++;
          if (hiCnt != expHi) begin
            mismatched++;
            $display("FAIL %s: high cycles=%0d expected=%0d", winReq, hiCnt, expHi);
          end
        end
        hiCnt    = 0;
        expHi    = (mAct == FULL) ? PERIOD : mAct;
        winReq   = curReq;
        winValid = 1'b1;
      end
      if (winValid && pwmOut === 1'b1) hiCnt++;
    end
  end

  task automatic finishRun();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  task automatic waitCycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic runDuty(string req, int d, int periods);
    curReq = req;
    duty   = 11'(d);
    waitCycles(periods * PERIOD);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: run did not finish, expected completion");
      finishRun();
    end
  end

  initial begin
    rstN = 1'b0; en = 1'b0; duty = 11'd1500;
    waitCycles(4);
    // R1: output low in reset
    compared++;
    if (pwmOut !== 1'b0) begin
      mismatched++;
      $display("FAIL R1: pwmOut=%0d expected=0", pwmOut);
    end
    checking = 1'b1;
    waitCycles(3);
    duty = 11'd0;
    curReq = "R5";
    rstN = 1'b1; en = 1'b1;
    waitCycles(2 * PERIOD);
    runDuty("R2", 1024, 2);
    runDuty("R3", 1, 2);
    runDuty("R3", 2046, 2);
    runDuty("R4", 17, 2);
    runDuty("R4", 32, 2);
    runDuty("R4", 33, 2);
    runDuty("R6", FULL, 3);
    runDuty("R3", 700, 2);
    runDuty("R5", 0, 2);
    // R7: change duty mid-period, twice
    runDuty("R7", 500, 1);
    waitCycles(300);
    duty = 11'd1500;
    waitCycles(400);
    duty = 11'd90;
    waitCycles(2 * PERIOD);
    // R8: drop enable mid-period, then resume with a new duty
    curReq = "R8";
    waitCycles(150);
    en = 1'b0;
    waitCycles(40);
    duty = 11'd900;
    waitCycles(10);
    en = 1'b1;
    waitCycles(3 * PERIOD);
    finishRun();
  end
endmodule